// File: doc/BRIEF.md
# Dual-Mode Serial Receive Controller

This block is the receive half of a serial port. It runs in one of two modes. In asynchronous mode it watches an idle-high line at sixteen samples per bit and turns each frame into a data word. A frame holds 7 or 8 data bits, sent least significant bit first, and may carry a parity bit. Each finished word is copied into a holding buffer, which is separate from the shift register. In clock-synchronous mode, software starts each 8-bit reception. Bits are then shifted in on an external bit strobe, and software reads the data straight from the shift register.

A single trigger bit in the control register decides who owns the receive path. In synchronous mode, writing 1 to it starts a reception. In asynchronous mode, writing 1 to it tells the block that the buffer has been consumed. If the next frame finishes before that write, the block flags an overrun, even when software had already read the data. Reading the trigger bit returns the receive-active status. Two sticky error flags, overrun and parity, are cleared by writing 1 to them. In synchronous slave mode, an active-low ready output tells the remote master that the receiver is armed.

Top module: `serial_rx_ctrl`

## Requirements
- R1: A write to address 0 with bit 0 set arms the trigger. In synchronous mode this starts an 8-bit reception. In asynchronous mode it releases the buffer. A write with bit 0 clear leaves the trigger unchanged.
- R2: Address 0 bit 0 reads the trigger, which is 1 while receiving. It resets to 0. It returns to 0 when the next frame completes, or in synchronous mode on the eighth bit strobe.
- R3: In asynchronous mode, a frame that completes while the trigger is 0 sets the overrun flag (address 0 bit 1). This happens even if the buffer was read before the frame ended.
- R4: The overrun flag (bit 1) and the parity flag (bit 2) are sticky. Writing 1 to a flag's bit clears it, and writing 0 leaves it unchanged.
- R5: While the receive-enable input is 0, both error flags and the trigger are held at 0. All three are also 0 after reset.
- R6: In asynchronous mode with parity enabled, a frame whose parity bit does not match sets the parity flag. Even parity is selected when the odd-select input is 0, odd parity when it is 1.
- R7: In asynchronous 7-bit mode, bit 7 of the data read from address 1 is 0, whether parity is on or off.
- R8: In asynchronous mode, address 1 returns the holding buffer, which keeps the previous word while the next frame shifts in. In synchronous mode, address 1 returns the shift register directly.
- R9: In synchronous slave mode, the ready output goes low on the clock edge that takes a trigger write. It returns high when the eighth bit is taken. In master mode it stays high.
- R10: An asynchronous frame starts on a falling edge of the line. The line is checked again on the 8th oversample tick, and a high level there abandons the frame. After that, the data bits, the parity bit and the stop bit are sampled every 16 ticks.
- R11: The rx_done output is high for exactly one clock per completed frame. That is the first clock in which the new word reads at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receive enable; 0 holds flags and trigger clear |
| sync_mode | input | 1 | 1 = clock-synchronous, 0 = asynchronous |
| slave_mode | input | 1 | Synchronous slave (drives ready output) |
| len8 | input | 1 | Asynchronous length: 1 = 8 bits, 0 = 7 bits |
| par_en | input | 1 | Asynchronous parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| os_tick | input | 1 | Oversample strobe, 16 per bit time |
| bit_tick | input | 1 | Synchronous bit strobe |
| sin | input | 1 | Serial data in |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 = control/status) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address (0 = control/status, 1 = data) |
| rd_data | output | 8 | Read data: {00000, parity, overrun, trigger} or received word |
| rdy_n | output | 1 | Active-low receiver-ready to the remote master |
| rx_done | output | 1 | One-cycle frame-complete pulse |

## Verification
The assertions assume two things about the inputs. The mode, length and parity controls do not change while a frame is in flight. Software writes never land on the same clock as a frame completion. The bench changes configuration only between frames, with the line idle. It issues its register writes before a frame starts or after it has ended. In synchronous mode it spaces bit strobes several clocks apart and leaves the oversample strobe high all the time. Each asynchronous bit therefore lasts exactly sixteen clocks.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned FRAME_W = 8;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);
  localparam int unsigned B_TRIG  = 0;
  localparam int unsigned B_OVR   = 1;
  localparam int unsigned B_PAR   = 2;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} rx_state_e;

  // index of the last data bit for the selected frame length
  function automatic logic [IDX_W-1:0] last_bit_index(input logic len8);
    return len8 ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
  endfunction

  // word as presented to software: top bit zeroed for short frames
  function automatic logic [FRAME_W-1:0] frame_word(input logic [FRAME_W-1:0] raw,
                                                    input logic len8);
    logic [FRAME_W-1:0] w;
    w = raw;
    if (!len8) w[FRAME_W-1] = 1'b0;
    return w;
  endfunction

  // 1 when the received parity bit disagrees with the selected sense
  function automatic logic parity_bad(input logic [FRAME_W-1:0] raw, input logic len8,
                                      input logic pbit, input logic odd);
    return (^frame_word(raw, len8)) ^ pbit ^ odd;
  endfunction
endpackage

// File: rtl/serial_rx_async.sv
module serial_rx_async
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               os_tick,
  input  logic               sin,
  input  logic               len8,
  input  logic               par_en,
  output logic               frame_done,
  output logic [FRAME_W-1:0] shift_q,
  output logic               par_bit
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(OSR - 1);

  rx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             sin_q;

  logic fall_seen, start_mid, bit_strobe;
  assign fall_seen  = sin_q && !sin;
  assign start_mid  = os_tick && (cnt == CNT_MID);
  assign bit_strobe = os_tick && (cnt == CNT_END);
  assign frame_done = en && (st == ST_STOP) && bit_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sin_q   <= 1'b1;
      shift_q <= '0;
      par_bit <= 1'b0;
    end else begin
      sin_q <= sin;
      if (!en) begin
        st  <= ST_IDLE;
        cnt <= '0;
        idx <= '0;
      end else begin
        unique case (st)
          ST_IDLE: if (fall_seen) begin
            st  <= ST_START;
            cnt <= '0;
          end
          ST_START: if (start_mid) begin
            cnt <= '0;
            idx <= '0;
            st  <= sin ? ST_IDLE : ST_DATA;
          end else if (os_tick) cnt <= cnt + 1'b1;
          ST_DATA: if (bit_strobe) begin
            shift_q[idx] <= sin;
            cnt <= '0;
            if (idx == last_bit_index(len8)) st <= par_en ? ST_PAR : ST_STOP;
            else idx <= idx + 1'b1;
          end else if (os_tick) cnt <= cnt + 1'b1;
          ST_PAR: if (bit_strobe) begin
            par_bit <= sin;
            cnt <= '0;
            st  <= ST_STOP;
          end else if (os_tick) cnt <= cnt + 1'b1;
          ST_STOP: if (bit_strobe) begin
            cnt <= '0;
            st  <= ST_IDLE;
          end else if (os_tick) cnt <= cnt + 1'b1;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_START && start_mid && sin) |=> (st == ST_IDLE));
endmodule

// File: rtl/serial_rx_sync.sv
module serial_rx_sync
  import serial_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               bit_tick,
  input  logic               sin,
  output logic               done,
  output logic [FRAME_W-1:0] shift_q
);
  logic [IDX_W-1:0] idx;

  assign done = active && bit_tick && (idx == IDX_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      shift_q <= '0;
    end else if (!active) begin
      idx <= '0;
    end else if (bit_tick) begin
      shift_q[idx] <= sin;
      idx          <= done ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs
  import serial_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               sync_mode,
  input  logic               len8,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic               rd_addr,
  input  logic               async_done,
  input  logic [FRAME_W-1:0] async_word,
  input  logic               async_pbit,
  input  logic               sync_done,
  input  logic [FRAME_W-1:0] sync_word,
  output logic [FRAME_W-1:0] rd_data,
  output logic               armed,
  output logic               rx_done
);
  logic               ovr_q, per_q;
  logic [FRAME_W-1:0] buf_q;

  logic ctl_wr, trig_wr, ovr_clr, per_clr, frame_evt, ovr_evt, par_evt;
  assign ctl_wr    = wr_en && (wr_addr == 1'b0);
  assign trig_wr   = ctl_wr && wr_data[B_TRIG];
  assign ovr_clr   = ctl_wr && wr_data[B_OVR];
  assign per_clr   = ctl_wr && wr_data[B_PAR];
  assign frame_evt = async_done || sync_done;
  assign ovr_evt   = async_done && !armed;
  assign par_evt   = async_done && par_en && parity_bad(async_word, len8, async_pbit, par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      ovr_q   <= 1'b0;
      per_q   <= 1'b0;
      buf_q   <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= frame_evt;
      if (async_done) buf_q <= frame_word(async_word, len8);
      if (!rx_en) begin
        armed <= 1'b0;
        ovr_q <= 1'b0;
        per_q <= 1'b0;
      end else begin
        if (trig_wr)        armed <= 1'b1;
        else if (frame_evt) armed <= 1'b0;
        if (ovr_evt)        ovr_q <= 1'b1;
        else if (ovr_clr)   ovr_q <= 1'b0;
        if (par_evt)        per_q <= 1'b1;
        else if (per_clr)   per_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == 1'b0) begin
      rd_data[B_TRIG] = armed;
      rd_data[B_OVR]  = ovr_q;
      rd_data[B_PAR]  = per_q;
    end else begin
      rd_data = sync_mode ? sync_word : buf_q;
    end
  end

  // R3
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && async_done && !armed) |=> ovr_q);

  // R4
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && ovr_q && !ovr_clr) |=> ovr_q);

  // R5
  en_off_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!ovr_q && !per_q && !armed));

  // R6
  par_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && par_evt) |=> per_q);

  // R7
  short_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (async_done && !len8) |=> !buf_q[FRAME_W-1]);

  // R2
  trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && trig_wr) |=> armed);
endmodule

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               sync_mode,
  input  logic               slave_mode,
  input  logic               len8,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               os_tick,
  input  logic               bit_tick,
  input  logic               sin,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic               rd_addr,
  output logic [FRAME_W-1:0] rd_data,
  output logic               rdy_n,
  output logic               rx_done
);
  logic               armed, async_on, sync_on;
  logic               async_done, async_pbit, sync_done;
  logic [FRAME_W-1:0] async_word, sync_word;

  assign async_on = rx_en && !sync_mode;
  assign sync_on  = rx_en && sync_mode && armed;
  assign rdy_n    = !(rx_en && sync_mode && slave_mode && armed);

  serial_rx_async #(.OSR(OSR)) u_async (
    .clk(clk), .rst_n(rst_n), .en(async_on), .os_tick(os_tick), .sin(sin),
    .len8(len8), .par_en(par_en), .frame_done(async_done),
    .shift_q(async_word), .par_bit(async_pbit)
  );

  serial_rx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .active(sync_on), .bit_tick(bit_tick), .sin(sin),
    .done(sync_done), .shift_q(sync_word)
  );

  serial_rx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sync_mode(sync_mode), .len8(len8),
    .par_en(par_en), .par_odd(par_odd), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .async_done(async_done),
    .async_word(async_word), .async_pbit(async_pbit), .sync_done(sync_done),
    .sync_word(sync_word), .rd_data(rd_data), .armed(armed), .rx_done(rx_done)
  );

  // R9
  rdy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && sync_mode && slave_mode && wr_en && !wr_addr && wr_data[B_TRIG]) |=> !rdy_n);

  // R11
  rx_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
endmodule

// File: tb/serial_rx_ctrl_tb.sv
module serial_rx_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, sync_mode = 1'b0, slave_mode = 1'b0;
  logic len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0;
  logic os_tick = 1'b1, bit_tick = 1'b0, sin = 1'b1;
  logic wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rdy_n, rx_done;

  int checks = 0, errors = 0, done_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_rx_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sync_mode(sync_mode),
    .slave_mode(slave_mode), .len8(len8), .par_en(par_en), .par_odd(par_odd),
    .os_tick(os_tick), .bit_tick(bit_tick), .sin(sin), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rdy_n(rdy_n), .rx_done(rx_done)
  );

  always @(posedge clk) if (rx_done) done_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  // expected data word and parity bit, computed bit by bit
  function automatic logic [7:0] want_word(input logic [7:0] d, input logic l8);
    return l8 ? d : (d & 8'h7F);
  endfunction

  function automatic logic want_pbit(input logic [7:0] d, input logic l8, input logic odd);
    int ones = 0;
    for (int i = 0; i < (l8 ? 8 : 7); i++) ones += int'(d[i]);
    return logic'(ones % 2) ^ odd;
  endfunction

  task automatic hold_bit(input logic b);
    @(negedge clk); sin = b;
    repeat (15) @(negedge clk);
  endtask

  task automatic send_async(input logic [7:0] d, input logic flip_par);
    hold_bit(1'b0);
    for (int i = 0; i < (len8 ? 8 : 7); i++) hold_bit(d[i]);
    if (par_en) hold_bit(want_pbit(d, len8, par_odd) ^ flip_par);
    hold_bit(1'b1);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_sync(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sin = d[i]; bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  initial begin
    logic [7:0] v;
    int prev;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    bus_rd(1'b0, v);
    chk("R2 reset status", v, 8'h00);
    chk("R5 reset ready", rdy_n, 1'b1);

    rx_en = 1'b1;
    @(negedge clk);

    // R1/R2: arm, receive, status drops
    bus_wr(1'b0, 8'h01);
    bus_rd(1'b0, v);
    chk("R2 armed status", v, 8'h01);
    prev = done_cnt;
    send_async(8'hA5, 1'b0);
    bus_rd(1'b1, v);
    chk("R8 async data", v, 8'hA5);
    bus_rd(1'b0, v);
    chk("R2 status after frame", v, 8'h00);
    chk("R11 one pulse per frame", done_cnt - prev, 1);

    // R1: writing 0 leaves trigger; R3: overrun even though buffer was read
    bus_wr(1'b0, 8'h00);
    bus_rd(1'b0, v);
    chk("R1 write zero no effect", v, 8'h00);
    bus_rd(1'b1, v);
    send_async(8'h3C, 1'b0);
    bus_rd(1'b0, v);
    chk("R3 overrun set", v[1], 1'b1);
    bus_rd(1'b1, v);
    chk("R8 buffer overwritten", v, 8'h3C);

    // R4 clear semantics
    bus_wr(1'b0, 8'h04);
    bus_rd(1'b0, v);
    chk("R4 write zero keeps overrun", v[1], 1'b1);
    bus_wr(1'b0, 8'h02);
    bus_rd(1'b0, v);
    chk("R4 write one clears overrun", v[1], 1'b0);

    // R6 parity error, even then odd
    par_en = 1'b1; par_odd = 1'b0;
    bus_wr(1'b0, 8'h01);
    send_async(8'h5A, 1'b1);
    bus_rd(1'b0, v);
    chk("R6 even parity error", v[2:1], 2'b10);
    bus_wr(1'b0, 8'h07);
    par_odd = 1'b1;
    send_async(8'h81, 1'b0);
    bus_rd(1'b0, v);
    chk("R6 odd parity good", v[2:1], 2'b00);

    // R7 7-bit with parity: top bit zero
    len8 = 1'b0;
    bus_wr(1'b0, 8'h01);
    send_async(8'hFF, 1'b0);
    bus_rd(1'b1, v);
    chk("R7 top bit zero", v, 8'h7F);
    bus_rd(1'b0, v);
    chk("R7 no parity error", v[2], 1'b0);
    par_en = 1'b0; len8 = 1'b1;

    // R10 false start ignored
    prev = done_cnt;
    @(negedge clk); sin = 1'b0;
    repeat (3) @(negedge clk);
    sin = 1'b1;
    repeat (40) @(negedge clk);
    chk("R10 glitch no frame", done_cnt - prev, 0);
    bus_rd(1'b1, v);
    chk("R10 glitch buffer kept", v, 8'h7F);

    // R8 buffer holds old word while next frame shifts
    bus_wr(1'b0, 8'h01);
    fork
      send_async(8'h96, 1'b0);
      begin
        logic [7:0] mv;
        repeat (80) @(negedge clk);
        bus_rd(1'b1, mv);
        chk("R8 old word mid-frame", mv, 8'h7F);
      end
    join
    bus_rd(1'b1, v);
    chk("R8 new word after frame", v, 8'h96);

    // R5 enable low clears flags
    send_async(8'h11, 1'b0);
    bus_rd(1'b0, v);
    chk("R3 overrun before disable", v[1], 1'b1);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk);
    bus_rd(1'b0, v);
    chk("R5 disable clears", v, 8'h00);
    rx_en = 1'b1;

    // random asynchronous frames
    for (int n = 0; n < 16; n++) begin
      logic [7:0] d;
      logic bad;
      d = 8'($urandom);
      len8 = 1'($urandom); par_en = 1'($urandom); par_odd = 1'($urandom);
      bad = par_en && (($urandom % 4) == 0);
      bus_wr(1'b0, 8'h07);
      send_async(d, bad);
      bus_rd(1'b1, v);
      chk("R8 random word", v, want_word(d, len8));
      bus_rd(1'b0, v);
      chk("R6 random flags", v, {5'b0, bad, 1'b0, 1'b0});
    end

    // synchronous slave
    sync_mode = 1'b1; slave_mode = 1'b1;
    @(negedge clk);
    chk("R9 ready idle high", rdy_n, 1'b1);
    bus_wr(1'b0, 8'h01);
    chk("R9 ready low after trigger", rdy_n, 1'b0);
    prev = done_cnt;
    send_sync(8'hC3);
    bus_rd(1'b1, v);
    chk("R8 sync bypass data", v, 8'hC3);
    bus_rd(1'b0, v);
    chk("R2 sync status cleared", v[0], 1'b0);
    chk("R9 ready high after eighth bit", rdy_n, 1'b1);
    chk("R11 sync pulse", done_cnt - prev, 1);

    // bit strobes with trigger clear do nothing (R1)
    send_sync(8'h00);
    bus_rd(1'b1, v);
    chk("R1 no reception without trigger", v, 8'hC3);

    // synchronous master: ready stays high
    slave_mode = 1'b0;
    bus_wr(1'b0, 8'h01);
    chk("R9 master ready high", rdy_n, 1'b1);
    send_sync(8'h5E);
    bus_rd(1'b1, v);
    chk("R1 master reception", v, 8'h5E);

    finished = 1;
    report();
  end
endmodule